// File: doc/BRIEF.md
# Per-Core Store Buffer with Load Forwarding

This block sits between a core's store port and its private cache. A committed store whose target line the cache cannot yet write is held in a small queue, so the core keeps running. A store that finds the queue empty and its line already writable goes straight to the cache. Queued stores leave the queue oldest first through the cache write port, one per cycle, whenever the cache reports that the oldest entry's line is writable. Nothing outside the core can see a queued store until it has been written to the cache.

Every load from the core is looked up in the queue before the cache value is used. If any queued store has the same address, the load returns the data of the youngest such store. Otherwise it returns the word the cache supplied. The controller is a three-state machine: `SB_EMPTY` (no entries), `SB_PARTIAL` (some entries, room left) and `SB_FULL` (every slot in use). The transitions are:
- `SB_EMPTY` to `SB_PARTIAL`: a store is queued.
- `SB_PARTIAL` to `SB_EMPTY`: the last entry drains with no store queued.
- `SB_PARTIAL` to `SB_FULL`: a store fills the last slot with no drain.
- `SB_FULL` to `SB_PARTIAL`: an entry drains.
- Every other case: the state stays where it is.

Top module: `stbuf_top`

## Requirements
- R1: After reset the queue is empty: `st_ready`=1, `head_valid`=0, `ld_hit_buf`=0, and `cw_en`=0 while no store is offered.
- R2: A store accepted with `st_line_wr`=0 is queued and causes no cache write in that cycle. While the oldest entry's line is not writable (`head_wr`=0), `cw_en` stays 0.
- R3: A store offered while the queue is empty and `st_line_wr`=1 bypasses the queue. It drives `cw_en`=1 with its own address and data in that same cycle and leaves no entry behind.
- R4: A load whose address (all `ADDR_W` bits compared) equals a queued entry's address returns that entry's data with `ld_hit_buf`=1. A load with no match returns `ld_cache_data` with `ld_hit_buf`=0.
- R5: When several queued entries match a load address, the data comes from the most recently accepted of them.
- R6: `head_addr` shows the oldest entry's address. When `head_valid`=1 and `head_wr`=1, that entry is written to the cache (`cw_en`=1, `cw_addr`/`cw_data` = the entry) in that cycle and removed. Entries leave in acceptance order, at most one per cycle.
- R7: With `DEPTH` entries queued, `st_ready`=0. A store offered while `st_ready`=0 is dropped: it is never written and never forwarded.
- R8: A store offered while the queue holds entries is queued even if `st_line_wr`=1, so it never overtakes older stores.
- R9: A load is checked only against entries present at the start of the cycle. A store accepted in the same cycle is not forwarded to that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a committed store |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_line_wr | input | 1 | Cache holds the line of `st_addr` writable |
| ld_valid | input | 1 | Core issues a load |
| ld_addr | input | ADDR_W | Load word address |
| ld_cache_data | input | DATA_W | Word read from the cache for `ld_addr` |
| ld_data | output | DATA_W | Load result (forwarded or cache) |
| ld_hit_buf | output | 1 | Load result came from the queue |
| head_valid | output | 1 | Queue holds at least one entry |
| head_addr | output | ADDR_W | Address of the oldest entry |
| head_wr | input | 1 | Cache holds the line of `head_addr` writable |
| cw_en | output | 1 | Cache write strobe |
| cw_addr | output | ADDR_W | Cache write address |
| cw_data | output | DATA_W | Cache write data |

## Verification
A short directed pass separates the bypass path from the queued path. It then fills the queue with two stores to one address and sweeps loads over every address, which tells a youngest match apart from an oldest match and a queue hit apart from a cache hit. Further patterns offer a store while the queue is full, offer a writable-line store while entries are pending, and put a load in the same cycle as a store to the same address, which separates a dropped store, order preservation, and start-of-cycle lookup. A long arithmetic mix of store, load and writability patterns then runs the queue through every occupancy, including simultaneous push and drain, with each output compared every cycle against a queue model kept in the bench.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY   = 2'd0,
        SB_PARTIAL = 2'd1,
        SB_FULL    = 2'd2
    } sb_state_e;

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic [DATA_W-1:0]              in_data,
    output logic [DEPTH-1:0][ADDR_W-1:0]   ord_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]   ord_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [PW-1:0]                rd_ptr;
    logic [PW-1:0]                wr_ptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        if (int'(p) == DEPTH - 1) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && int'(wr_ptr) == g) begin
                    slot_addr[g] <= in_addr;
                    slot_data[g] <= in_data;
                end
            end
        end
    endgenerate

    // Age-ordered view: index 0 is the oldest entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = (int'(rd_ptr) + i) % DEPTH;
            ord_addr[i] = slot_addr[s];
            ord_data[i] = slot_data[s];
        end
    end

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0]              ld_addr,
    input  logic [CW-1:0]                  cnt,
    input  logic [DEPTH-1:0][ADDR_W-1:0]   ord_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]   ord_data,
    output logic                           hit,
    output logic [DATA_W-1:0]              data
);
    // Ascending age scan: the last match seen is the youngest.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt) && ord_addr[i] == ld_addr) begin
                hit  = 1'b1;
                data = ord_data[i];
            end
        end
    end

endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic          st_line_wr,
    input  logic          head_wr,
    output logic          st_ready,
    output logic          push,
    output logic          pop,
    output logic          bypass,
    output logic          head_valid,
    output logic [CW-1:0] cnt
);
    sb_state_e     state;
    sb_state_e     state_nx;
    logic [CW-1:0] cnt_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SB_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        st_ready   = 1'b0;
        push       = 1'b0;
        pop        = 1'b0;
        bypass     = 1'b0;
        head_valid = 1'b0;
        unique case (state)
            SB_EMPTY: begin
                st_ready = 1'b1;
                bypass   = st_valid && st_line_wr;
                push     = st_valid && !st_line_wr;
            end
            SB_PARTIAL: begin
                st_ready   = 1'b1;
                head_valid = 1'b1;
                push       = st_valid;
                pop        = head_wr;
            end
            SB_FULL: begin
                head_valid = 1'b1;
                pop        = head_wr;
            end
            default: begin
                st_ready = 1'b0;
            end
        endcase
    end

    always_comb begin
        cnt_nx = cnt + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
        if (cnt_nx == '0) begin
            state_nx = SB_EMPTY;
        end else if (int'(cnt_nx) == DEPTH) begin
            state_nx = SB_FULL;
        end else begin
            state_nx = SB_PARTIAL;
        end
    end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_line_wr,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_cache_data,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_hit_buf,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    input  logic              head_wr,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic                         push;
    logic                         pop;
    logic                         bypass;
    logic [CW-1:0]                cnt;
    logic [DEPTH-1:0][ADDR_W-1:0] ord_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ord_data;
    logic                         fwd_hit;
    logic [DATA_W-1:0]            fwd_data;

    stbuf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid),
        .st_line_wr (st_line_wr),
        .head_wr    (head_wr),
        .st_ready   (st_ready),
        .push       (push),
        .pop        (pop),
        .bypass     (bypass),
        .head_valid (head_valid),
        .cnt        (cnt)
    );

    stbuf_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .in_addr  (st_addr),
        .in_data  (st_data),
        .ord_addr (ord_addr),
        .ord_data (ord_data)
    );

    stbuf_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_fwd (
        .ld_addr  (ld_addr),
        .cnt      (cnt),
        .ord_addr (ord_addr),
        .ord_data (ord_data),
        .hit      (fwd_hit),
        .data     (fwd_data)
    );

    assign head_addr  = ord_addr[0];
    assign ld_hit_buf = ld_valid && fwd_hit;
    assign ld_data    = fwd_hit ? fwd_data : ld_cache_data;
    assign cw_en      = bypass || pop;
    assign cw_addr    = bypass ? st_addr : ord_addr[0];
    assign cw_data    = bypass ? st_data : ord_data[0];

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              st_line_wr,
    input logic              ld_valid,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] ld_cache_data,
    input logic              ld_hit_buf,
    input logic              head_valid,
    input logic [ADDR_W-1:0] head_addr,
    input logic              head_wr,
    input logic              cw_en,
    input logic [ADDR_W-1:0] cw_addr,
    input logic [CW-1:0]     cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= DEPTH); // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) == DEPTH) |-> !st_ready); // R7
    AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && !head_valid) |-> (st_valid && st_line_wr)); // R3
    AST_HELD_INVISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !head_wr) |-> !cw_en); // R2
    AST_DRAIN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_wr) |-> (cw_en && cw_addr == head_addr)); // R6
    AST_CACHE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_hit_buf) |-> (ld_data == ld_cache_data)); // R4
    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> !ld_hit_buf); // R4
    AST_KEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && st_valid && st_ready) |=> (cnt != '0)); // R8
endmodule

bind stbuf_top stbuf_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_line_wr    (st_line_wr),
    .ld_valid      (ld_valid),
    .ld_data       (ld_data),
    .ld_cache_data (ld_cache_data),
    .ld_hit_buf    (ld_hit_buf),
    .head_valid    (head_valid),
    .head_addr     (head_addr),
    .head_wr       (head_wr),
    .cw_en         (cw_en),
    .cw_addr       (cw_addr),
    .cnt           (cnt)
);

// File: tb/stbuf_top_bench.sv
`timescale 1ns/1ps
module stbuf_top_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_line_wr = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_cache_data = '0;
    logic [DW-1:0] ld_data;
    logic          ld_hit_buf;
    logic          head_valid;
    logic [AW-1:0] head_addr;
    logic          head_wr = 1'b0;
    logic          cw_en;
    logic [AW-1:0] cw_addr;
    logic [DW-1:0] cw_data;

    int n_checks = 0;
    int n_fail = 0;

    // Bench model: cache contents and queue contents, oldest at index 0.
    logic [DW-1:0] mem [NA];
    logic [AW-1:0] mq_a [DP];
    logic [DW-1:0] mq_d [DP];
    int            mcnt = 0;

    always #10 clk = ~clk;

    stbuf_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u_stbuf_top (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_line_wr(st_line_wr),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_cache_data(ld_cache_data),
        .ld_data(ld_data), .ld_hit_buf(ld_hit_buf), .head_valid(head_valid),
        .head_addr(head_addr), .head_wr(head_wr), .cw_en(cw_en),
        .cw_addr(cw_addr), .cw_data(cw_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input logic slw, input logic lv, input logic [AW-1:0] la,
                        input logic hw, input string ovr);
        bit            e_rdy, e_byp, e_pop, e_cw, e_hit;
        int            nm;
        logic [DW-1:0] e_ld, fd;
        logic [AW-1:0] e_ca;
        logic [DW-1:0] e_cd;
        string         t;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_line_wr = slw;
        ld_valid = lv; ld_addr = la; ld_cache_data = mem[la]; head_wr = hw;
        #2;
        e_rdy = (mcnt < DP);
        e_byp = (mcnt == 0) && sv && slw;
        e_pop = (mcnt > 0) && hw;
        e_cw  = e_byp || e_pop;
        e_ca  = e_byp ? sa : mq_a[0];
        e_cd  = e_byp ? sd : mq_d[0];
        nm = 0; fd = '0;
        for (int j = 0; j < mcnt; j++) begin
            if (mq_a[j] == la) begin
                nm++;
                fd = mq_d[j];
            end
        end
        e_hit = lv && (nm > 0);
        e_ld  = (nm > 0) ? fd : mem[la];

        t = (ovr != "") ? ovr : "R7";
        chk(st_ready == e_rdy, t, "st_ready", int'(st_ready), int'(e_rdy));
        t = (ovr != "") ? ovr : "R6";
        chk(head_valid == (mcnt > 0), t, "head_valid", int'(head_valid), int'(mcnt > 0));
        if (mcnt > 0) chk(head_addr == mq_a[0], t, "head_addr", int'(head_addr), int'(mq_a[0]));
        t = (ovr != "") ? ovr : (e_byp ? "R3" : (e_pop ? "R6" : "R2"));
        chk(cw_en == e_cw, t, "cw_en", int'(cw_en), int'(e_cw));
        if (e_cw) begin
            chk(cw_addr == e_ca, t, "cw_addr", int'(cw_addr), int'(e_ca));
            chk(cw_data == e_cd, t, "cw_data", int'(cw_data), int'(e_cd));
        end
        t = (ovr != "") ? ovr : ((nm > 1) ? "R5" : "R4");
        chk(ld_hit_buf == e_hit, t, "ld_hit_buf", int'(ld_hit_buf), int'(e_hit));
        if (lv) chk(ld_data == e_ld, t, "ld_data", int'(ld_data), int'(e_ld));

        if (e_cw) mem[e_ca] = e_cd;
        if (e_pop) begin
            for (int j = 0; j < DP - 1; j++) begin
                mq_a[j] = mq_a[j+1];
                mq_d[j] = mq_d[j+1];
            end
            mcnt--;
        end
        if (sv && e_rdy && !e_byp) begin
            mq_a[mcnt] = sa;
            mq_d[mcnt] = sd;
            mcnt++;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < NA; a++) mem[a] = DW'(a * 17 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(st_ready == 1'b1, "R1", "st_ready", int'(st_ready), 1);
        chk(head_valid == 1'b0, "R1", "head_valid", int'(head_valid), 0);
        chk(cw_en == 1'b0, "R1", "cw_en", int'(cw_en), 0);
        chk(ld_hit_buf == 1'b0, "R1", "ld_hit_buf", int'(ld_hit_buf), 0);

        // Bypass on empty, then the load sees the cache copy.
        step(1, 4'd3, 8'hA1, 1, 1, 4'd3, 0, "");
        step(0, 4'd0, 8'h00, 0, 1, 4'd3, 0, "");
        // Fill with two stores to address 2 among others.
        step(1, 4'd2, 8'h21, 0, 1, 4'd2, 0, "");
        step(1, 4'd6, 8'h61, 0, 1, 4'd2, 0, "");
        step(1, 4'd2, 8'h22, 0, 1, 4'd2, 0, "");
        step(1, 4'd9, 8'h91, 0, 1, 4'd6, 0, "");
        // Full: store dropped; sweep loads over every address.
        step(1, 4'd7, 8'h77, 1, 1, 4'd7, 0, "R7");
        for (int a = 0; a < NA; a++) step(0, 4'd0, 8'h00, 0, 1, AW'(a), 0, "");
        // Drain in order.
        for (int k = 0; k < DP; k++) step(0, 4'd0, 8'h00, 0, 1, 4'd2, 1, "");
        step(0, 4'd0, 8'h00, 0, 1, 4'd7, 0, "R7");
        // Writable-line store behind a pending one must queue.
        step(1, 4'd4, 8'h41, 0, 0, 4'd0, 0, "");
        step(1, 4'd5, 8'h51, 1, 1, 4'd5, 0, "R8");
        step(0, 4'd0, 8'h00, 0, 1, 4'd5, 0, "R8");
        step(0, 4'd0, 8'h00, 0, 1, 4'd5, 1, "R8");
        step(0, 4'd0, 8'h00, 0, 1, 4'd5, 1, "R8");
        // Same-cycle store and load to one address.
        step(1, 4'd8, 8'h11, 0, 0, 4'd0, 0, "");
        step(1, 4'd8, 8'h22, 0, 1, 4'd8, 0, "R9");
        step(0, 4'd0, 8'h00, 0, 1, 4'd8, 0, "R9");
        // Arithmetic mix across all occupancies.
        for (int k = 0; k < 600; k++) begin
            step(k % 3 != 0, AW'(k * 7 + k / 5), DW'(k * 13 + 1),
                 (k % 5 == 0) || (k % 7 == 0), k % 6 != 5, AW'(k * 3 + k / 4),
                 (k % 4 != 1) && (k % 9 != 0), "");
        end
        for (int k = 0; k < DP + 1; k++) step(0, 4'd0, 8'h00, 0, 1, AW'(k), 1, "");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule